// File: doc/BRIEF.md
# Store and Recall Protection Controller

This block sits between a serial command decoder and a pair of 16-word by 16-bit arrays. One is a working RAM and the other is a nonvolatile shadow copy of it. The block holds two protection latches. The write-enable latch gates RAM writes and stores. The recalled latch records that a deliberate recall has been performed since power-up. The block decides when a bulk copy may run. A recall copies the shadow into the RAM. A store copies the RAM into the shadow.

Commands reach the block as single-cycle pulses from the decoder. Recalls and stores can also be requested through two active-low pins. These pins are synchronised and act once per falling edge. A store lasts a parameterised number of cycles. During that time `busy` is high and every other operation is locked out. At the end of that time all words are copied at once and the write-enable latch drops.

The nonvolatile cells are modelled as a register array. This array takes a computed pattern at the first reset. It then changes only by store.

Top module: `nvg_guard`

## Requirements
- R1: A recall request copies every shadow word into the RAM at the clock edge where it is taken, and it sets `recalled_state`. A recall request is either a `cmd_recall` pulse or a falling edge on `recall_pin_n`.
- R2: After reset, `wen_state` and `recalled_state` are both 0. The automatic power-up recall leaves `recalled_state` at 0.
- R3: A `cmd_wren` pulse sets `wen_state`. A `cmd_wrds` pulse clears it. If both pulses arrive in the same cycle, the latch ends up cleared.
- R4: A `wr_req` writes `wr_data` into RAM word `wr_addr` only while `wen_state` is 1. Otherwise the RAM is unchanged.
- R5: A store starts only when a store request (a `cmd_store` pulse or a falling edge on `store_pin_n`) arrives while both latches are 1. A request that fails this test is ignored and leaves both latches unchanged.
- R6: While a store runs, these inputs have no effect: command pulses, RAM writes and pin edges.
- R7: When a store completes, `wen_state` is 0 and `recalled_state` keeps its value of 1.
- R8: `busy` is high for exactly STORE_CYCLES cycles (default 20), starting with the cycle after the request is taken. At its end, the shadow holds the RAM contents as they were at that point.
- R9: In the first cycle after reset is released, `busy` is 1 while the shadow is copied into the RAM. After the first reset, shadow word i holds SEED + i*STEP modulo 2^WIDTH. The defaults are SEED 0xA5C3 and STEP 0x0101.
- R10: Each pin passes through SYNC_STAGES flops and is edge-detected. A falling edge acts within SYNC_STAGES+1 cycles. A pin held low triggers no further operation.
- R11: If a recall and a store are requested in the same cycle, only the recall is performed. In that case `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_wren | input | 1 | Pulse: set write-enable latch |
| cmd_wrds | input | 1 | Pulse: clear write-enable latch |
| cmd_store | input | 1 | Pulse: request store |
| cmd_recall | input | 1 | Pulse: request recall |
| store_pin_n | input | 1 | Asynchronous active-low store request |
| recall_pin_n | input | 1 | Asynchronous active-low recall request |
| wr_req | input | 1 | RAM write request |
| wr_addr | input | 4 | RAM write word address |
| wr_data | input | 16 | RAM write data |
| rd_addr | input | 4 | RAM read word address |
| rd_data | output | 16 | RAM read data (combinational) |
| busy | output | 1 | Store or power-up recall in progress |
| wen_state | output | 1 | Write-enable latch |
| recalled_state | output | 1 | Recalled latch |

## Verification
Suppose a latch takes a wrong value. The next write or store then succeeds or fails against expectation. The effect shows up at `rd_data` on the next read, or in whether `busy` rises in the cycle after the request. Suppose instead the store timer is miscounted. Then `busy` falls a cycle early or late, and the bench counts that length directly. A missing or extra bulk copy only becomes visible after a later recall brings the shadow back into the RAM. For that reason the bench follows each store with a modified RAM word and a recall, and keeps a model of both arrays.

// File: rtl/nvg_pkg.sv
package nvg_pkg;

    typedef enum logic [1:0] {
        MODE_PWRUP = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_STORE = 2'd2
    } mode_e;

    typedef struct packed {
        logic wren;
        logic wrds;
        logic store;
        logic recall;
    } req_t;

endpackage

// File: rtl/nvg_pin_sync.sv
module nvg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int NREG = STAGES + 1;

    logic [NREG-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[NREG-2:0], pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    // Previous synchronised level high, current synchronised level low.
    assign fall = chain_q[NREG-1] & ~chain_q[NREG-2];

endmodule

// File: rtl/nvg_guard_fsm.sv
module nvg_guard_fsm
    import nvg_pkg::*;
#(
    parameter int STORE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  req_t req,
    output logic wen,
    output logic prev,
    output logic busy,
    output logic storing,
    output logic do_recall,
    output logic do_store
);
    localparam int CW = $clog2(STORE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STORE_CYCLES - 1);

    typedef struct packed {
        mode_e         mode;
        logic          wen;
        logic          prev;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        do_recall = 1'b0;
        do_store  = 1'b0;
        case (s_q.mode)
            MODE_PWRUP: begin
                do_recall = 1'b1;
                s_d.mode  = MODE_IDLE;
            end
            MODE_IDLE: begin
                if (req.wren) s_d.wen = 1'b1;
                if (req.wrds) s_d.wen = 1'b0;
                if (req.recall) begin
                    do_recall = 1'b1;
                    s_d.prev  = 1'b1;
                end else if (req.store && s_q.wen && s_q.prev) begin
                    s_d.mode = MODE_STORE;
                    s_d.cnt  = LAST;
                end
            end
            MODE_STORE: begin
                if (s_q.cnt == '0) begin
                    do_store = 1'b1;
                    s_d.wen  = 1'b0;
                    s_d.mode = MODE_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_PWRUP, wen: 1'b0, prev: 1'b0, cnt: '0};
        else        s_q <= s_d;
    end

    assign wen     = s_q.wen;
    assign prev    = s_q.prev;
    assign storing = (s_q.mode == MODE_STORE);
    assign busy    = (s_q.mode != MODE_IDLE);

    // R5: a store only begins from a state with both latches set
    p_store_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(storing) |-> ($past(s_q.wen) && $past(s_q.prev)));

    // R7: leaving the store clears the write-enable latch
    p_wen_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(storing) |-> (!wen && prev));

    // R2: the power-up recall does not set the recalled latch
    p_por_prev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_PWRUP) |=> !prev);

    // R1: an accepted recall sets the recalled latch
    p_recall_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_IDLE && req.recall) |=> prev);

    // R11: recall wins over a simultaneous store
    p_recall_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_IDLE && req.recall && req.store) |=> !storing);

endmodule

// File: rtl/nvg_arrays.sv
module nvg_arrays #(
    parameter int              DEPTH = 16,
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] SEED = 16'hA5C3,
    parameter logic [WIDTH-1:0] STEP = 16'h0101,
    localparam int             AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_recall,
    input  logic             do_store,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    typedef logic [WIDTH-1:0] mem_t [DEPTH];

    mem_t ram_d, ram_q;
    mem_t sh_d,  sh_q;

    function automatic logic [WIDTH-1:0] first_word(input int idx);
        return SEED + STEP * WIDTH'(idx);
    endfunction

    always_comb begin
        ram_d = ram_q;
        sh_d  = sh_q;
        if (do_recall)  ram_d = sh_q;
        else if (wr_en) ram_d[wr_addr] = wr_data;
        if (do_store)   sh_d = ram_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ram_q[i] <= '0;
                sh_q[i]  <= first_word(i);
            end
        end else begin
            ram_q <= ram_d;
            sh_q  <= sh_d;
        end
    end

    assign rd_data = ram_q[rd_addr];

    // R1: a recall lands shadow contents in the RAM
    p_recall_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        do_recall |=> (ram_q[DEPTH-1] == $past(sh_q[DEPTH-1])));

    // R8: the end of a store lands RAM contents in the shadow
    p_store_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_store |=> (sh_q[0] == $past(ram_q[0])));

endmodule

// File: rtl/nvg_guard.sv
module nvg_guard
    import nvg_pkg::*;
#(
    parameter int              DEPTH        = 16,
    parameter int              WIDTH        = 16,
    parameter int              STORE_CYCLES = 20,
    parameter int              SYNC_STAGES  = 2,
    parameter logic [WIDTH-1:0] SEED        = 16'hA5C3,
    parameter logic [WIDTH-1:0] STEP        = 16'h0101,
    localparam int             AW           = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wren,
    input  logic             cmd_wrds,
    input  logic             cmd_store,
    input  logic             cmd_recall,
    input  logic             store_pin_n,
    input  logic             recall_pin_n,
    input  logic             wr_req,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             wen_state,
    output logic             recalled_state
);
    localparam int NPINS = 2;
    localparam int PIN_STORE  = 0;
    localparam int PIN_RECALL = 1;

    logic [NPINS-1:0] pins_n, falls;
    req_t req;
    logic storing, do_recall, do_store, wr_en;

    assign pins_n = {recall_pin_n, store_pin_n};

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        nvg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (pins_n[g]),
            .fall  (falls[g])
        );
    end

    always_comb begin
        req.wren   = cmd_wren;
        req.wrds   = cmd_wrds;
        req.store  = cmd_store  | falls[PIN_STORE];
        req.recall = cmd_recall | falls[PIN_RECALL];
    end

    nvg_guard_fsm #(.STORE_CYCLES(STORE_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .wen       (wen_state),
        .prev      (recalled_state),
        .busy      (busy),
        .storing   (storing),
        .do_recall (do_recall),
        .do_store  (do_store)
    );

    assign wr_en = wr_req & wen_state & ~busy;

    nvg_arrays #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .SEED  (SEED),
        .STEP  (STEP)
    ) u_arrays (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_recall (do_recall),
        .do_store  (do_store),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // R6: no RAM word changes across a cycle spent storing
    p_no_change_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(storing) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

// File: tb/nvg_guard_bench.sv
module nvg_guard_bench;
    localparam int SC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren = 0, cmd_wrds = 0, cmd_store = 0, cmd_recall = 0;
    logic        store_pin_n = 1, recall_pin_n = 1;
    logic        wr_req = 0;
    logic [3:0]  wr_addr = 0, rd_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        busy, wen_state, recalled_state;

    always #10 clk = ~clk;

    nvg_guard #(.STORE_CYCLES(SC)) u_nvg_guard (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrds(cmd_wrds),
        .cmd_store(cmd_store), .cmd_recall(cmd_recall),
        .store_pin_n(store_pin_n), .recall_pin_n(recall_pin_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .wen_state(wen_state), .recalled_state(recalled_state)
    );

    typedef struct { logic [15:0] d; int a; string tag; } exp_t;
    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    logic rd_chk = 0;
    logic finished = 0;

    logic [15:0] ram_m [16];
    logic [15:0] sh_m  [16];
    logic        m_wen = 0;

    function automatic logic [15:0] first_word(int i);
        return 16'hA5C3 + 16'(i) * 16'h0101;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rd(int a, string tag);
        exp_t e;
        e.d = ram_m[a]; e.a = a; e.tag = tag;
        rd_addr = 4'(a);
        exp_q.push_back(e);
        rd_chk = 1;
        tick(1);
        rd_chk = 0;
    endtask

    task automatic wr(int a, logic [15:0] d);
        wr_req = 1; wr_addr = 4'(a); wr_data = d;
        tick(1);
        wr_req = 0;
        if (m_wen) ram_m[a] = d;
    endtask

    task automatic do_recall_model();
        for (int i = 0; i < 16; i++) ram_m[i] = sh_m[i];
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (rd_chk && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(rd_data == e.d, e.tag, int'(rd_data), int'(e.d));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        bit seen;
        for (int i = 0; i < 16; i++) begin
            sh_m[i] = first_word(i);
            ram_m[i] = sh_m[i];
        end
        tick(3);
        rst_n = 1;
        // cycle right after release: power-up recall in progress
        check(busy == 1, "R9 busy during power-up recall", busy, 1);
        check(wen_state == 0 && recalled_state == 0, "R2 latches after reset",
              {wen_state, recalled_state}, 0);
        tick(1);
        check(busy == 0, "R9 busy drops after power-up recall", busy, 0);
        check(recalled_state == 0, "R2 power-up recall leaves latch clear", recalled_state, 0);
        for (int i = 0; i < 16; i++) rd(i, "R9 power-up contents");

        // R4: write without enable is dropped
        wr(3, 16'h1234);
        rd(3, "R4 write blocked without enable");

        // R3 set / clear
        cmd_wren = 1; tick(1); cmd_wren = 0; m_wen = 1;
        check(wen_state == 1, "R3 wren sets latch", wen_state, 1);
        wr(3, 16'h1234);
        rd(3, "R4 write with enable");
        cmd_wrds = 1; tick(1); cmd_wrds = 0; m_wen = 0;
        check(wen_state == 0, "R3 wrds clears latch", wen_state, 0);
        cmd_wren = 1; cmd_wrds = 1; tick(1); cmd_wren = 0; cmd_wrds = 0;
        check(wen_state == 0, "R3 simultaneous wren and wrds", wen_state, 0);

        // R5: store without recalled latch ignored
        cmd_wren = 1; tick(1); cmd_wren = 0; m_wen = 1;
        cmd_store = 1; tick(1); cmd_store = 0;
        check(busy == 0, "R5 store refused without recall", busy, 0);
        check(wen_state == 1 && recalled_state == 0, "R5 latches unchanged",
              {wen_state, recalled_state}, 2);

        // R1 recall
        cmd_recall = 1; tick(1); cmd_recall = 0; do_recall_model();
        check(recalled_state == 1, "R1 recall sets latch", recalled_state, 1);
        rd(3, "R1 recall restores word");

        for (int i = 0; i < 4; i++) wr(i, 16'h1000 + 16'(i));

        // store with lockout
        cmd_store = 1; tick(1); cmd_store = 0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            wr_req = 1; wr_addr = 4'd5; wr_data = 16'hDEAD;
            cmd_recall = 1; cmd_wren = 1;
            tick(1);
        end
        wr_req = 0; cmd_recall = 0; cmd_wren = 0;
        for (int i = 0; i < 16; i++) sh_m[i] = ram_m[i];
        m_wen = 0;
        check(cnt == SC, "R8 busy length", cnt, SC);
        check(wen_state == 0, "R7 store clears wen", wen_state, 0);
        check(recalled_state == 1, "R7 recalled latch kept", recalled_state, 1);
        rd(5, "R6 write during store ignored");
        rd(0, "R6 recall during store ignored");

        // R8 shadow holds stored data
        cmd_wren = 1; tick(1); cmd_wren = 0; m_wen = 1;
        wr(0, 16'hFFFF);
        rd(0, "R4 overwrite before recall");
        cmd_recall = 1; tick(1); cmd_recall = 0; do_recall_model();
        rd(0, "R8 shadow updated by store");
        rd(5, "R8 untouched word in shadow");

        // R10 recall pin, held low
        wr(7, 16'h7777);
        recall_pin_n = 0; tick(5); do_recall_model();
        rd(7, "R10 recall pin edge");
        wr(7, 16'h7777);
        tick(5);
        rd(7, "R10 held recall pin no repeat");
        recall_pin_n = 1; tick(3);

        // R10 store pin
        check(wen_state == 1 && recalled_state == 1, "R10 latches before pin store",
              {wen_state, recalled_state}, 3);
        store_pin_n = 0;
        seen = 0;
        for (int i = 0; i < 4 && !seen; i++) begin
            tick(1);
            if (busy) seen = 1;
        end
        check(seen, "R10 store pin starts store", seen, 1);
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; tick(1); end
        for (int i = 0; i < 16; i++) sh_m[i] = ram_m[i];
        m_wen = 0;
        cmd_wren = 1; tick(1); cmd_wren = 0; m_wen = 1;
        tick(5);
        check(busy == 0, "R10 held store pin no repeat", busy, 0);
        store_pin_n = 1; tick(3);

        // R11 priority
        wr(2, 16'h2222);
        cmd_recall = 1; cmd_store = 1; tick(1); cmd_recall = 0; cmd_store = 0;
        do_recall_model();
        check(busy == 0, "R11 recall wins over store", busy, 0);
        check(wen_state == 1, "R11 wen unchanged", wen_state, 1);
        rd(2, "R11 recall performed");
        rd(7, "R10 pin store captured word");

        tick(2);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule